// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block brings a bank of asynchronous DRAM out of power-up and then keeps it refreshed. Once reset is released it counts out the power-up pause. It then runs a burst of initial refresh cycles. Only after the last of those cycles has finished precharging does it raise `init_done`, which tells the access sequencer that normal reads and writes may begin. From then on an interval timer adds one refresh to a pending counter each period. The array needs 4096 refreshes every 64 ms, which is one refresh every 15.625 µs on average.

The block shares the DRAM strobes with an access sequencer through a request/grant pair. It holds `ref_req` high while any refresh is pending or a refresh cycle is running. While `ref_gnt` is also high it raises `str_drv` and supplies the /RAS, /CAS and /WE values that the bus multiplexer merges in. Each cycle is of the kind where /CAS falls before /RAS, so the DRAM's internal counter supplies the row and no address is driven. All /CAS lines switch together and /WE stays high. Refreshes that are postponed because the grant is withheld are stored in the pending counter. That counter saturates and latches an error flag if one more arrives when it is full.

All delays are clock-cycle counts, with 10 ns assumed per cycle. A `FAST_SIM` parameter swaps the power-up and interval counts for short values.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and right after it, `ras_n`, `we_n` and every `cas_n` bit are 1. `str_drv`, `ref_req`, `init_done` and `pend_ovf` are 0.
- R2: `ref_req` stays low until the power-up pause has elapsed, counted from reset release (`PWRUP_SIM_CYC` = 50 cycles in fast mode, plus two cycles of reset synchronization). It rises within three cycles after that.
- R3: Exactly `INIT_REFS` (8) refresh cycles run before `init_done` rises. `init_done` rises only once `ref_req` has fallen after the last precharge, and it stays low while those refreshes are outstanding.
- R4: During a driven cycle all `CAS_LINES` bits of `cas_n` always carry the same value.
- R5: /CAS is low for at least `SETUP_CYC` (1) cycle before /RAS falls, and it is still low in the cycle /RAS falls. `we_n` is 1 in every driven cycle.
- R6: /RAS stays low for exactly `RAS_LOW_CYC` (6) cycles. /CAS stays low for exactly `CHR_CYC` (1) of those cycles, starting at the /RAS fall, and then returns high.
- R7: /RAS is high for at least `RAS_PRE_CYC` (4) cycles before it falls again. /CAS only falls while /RAS is high.
- R8: While `ref_gnt` is 0, `str_drv` is 0 and all strobe outputs are 1 (inactive).
- R9: After `init_done`, a refresh request arrives every `REF_INT_SIM_CYC` (200) cycles in fast mode, so successive rises of `ref_req` are exactly that far apart.
- R10: Refreshes that arrive while the grant is withheld accumulate, and `ref_req` stays high meanwhile. Once the grant returns they run back to back, exactly as many as were postponed, and `ref_req` falls after the last one's precharge.
- R11: The pending counter holds at most `PEND_MAX` (8) refreshes. A request that arrives when it is full is dropped and sets `pend_ovf`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (10 ns assumed for the cycle counts) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_gnt | input | 1 | Bus grant from the access sequencer |
| ref_req | output | 1 | Bus request: refresh pending or in progress |
| init_done | output | 1 | Power-up pause and initial refreshes complete |
| str_drv | output | 1 | Strobe values below are valid and must be merged onto the bus |
| ras_n | output | 1 | Row strobe value (active low) |
| cas_n | output | CAS_LINES | Column strobe values, all switched together (active low) |
| we_n | output | 1 | Write-enable value, held high during refresh |
| pend_ovf | output | 1 | Sticky flag: a refresh was lost to pending-counter saturation |

## Verification
The bound checker checks the strobe ordering on every cycle: /CAS is low when /RAS falls and on the cycle before, /CAS falls only while /RAS is high, there is no drive without a grant, the request holds through every /RAS-low cycle, init-done rises only with the request low, and the overflow flag is sticky. The bench scenarios cover the behaviour that depends on counts and history. That is the length of the power-up pause, the exact number of initial refreshes, the /RAS pulse and precharge widths, the refresh period, and whether exactly the postponed refreshes are replayed back to back. They also show that the pending count clips at eight when a ninth request arrives.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_HOLD  = 3'd2,
    PH_RASLO = 3'd3,
    PH_PRE   = 3'd4
  } dref_ph_e;
endpackage

// File: rtl/dref_tick_timer.sv
module dref_tick_timer #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dref_pend_ctr.sv
module dref_pend_ctr #(
  parameter int PEND_MAX  = 8,
  parameter int INIT_REFS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  logic inc,
  input  logic dec,
  output logic nz,
  output logic ovf
);
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full;

  assign full = (cnt_q == PW'(PEND_MAX));
  assign nz   = (cnt_q != '0);
  assign ovf  = ovf_q;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (ld) begin
      cnt_d = PW'(INIT_REFS);
    end else begin
      unique case ({inc, dec})
        2'b10: begin
          if (full) ovf_d = 1'b1;
          else      cnt_d = cnt_q + 1'b1;
        end
        2'b01:   if (nz) cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/dref_strobe_seq.sv
module dref_strobe_seq
  import dref_pkg::*;
#(
  parameter int SETUP_CYC   = 1,
  parameter int CHR_CYC     = 1,
  parameter int RAS_LOW_CYC = 6,
  parameter int PRE_CYC     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic start_ok,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int SUMC = SETUP_CYC + RAS_LOW_CYC + PRE_CYC;
  localparam int PCW  = $clog2(SUMC + 1);

  dref_ph_e      ph_q, ph_d;
  logic [PCW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last  = (cnt_q == '0);
  assign busy  = (ph_q != PH_IDLE);
  assign ras_n = !((ph_q == PH_HOLD) || (ph_q == PH_RASLO));
  assign cas_n = !((ph_q == PH_SETUP) || (ph_q == PH_HOLD));

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    done  = 1'b0;
    if (ce) begin
      unique case (ph_q)
        PH_IDLE: if (start_ok) begin
          ph_d  = PH_SETUP;
          cnt_d = PCW'(SETUP_CYC - 1);
        end
        PH_SETUP: if (last) begin
          ph_d  = PH_HOLD;
          cnt_d = PCW'(CHR_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
        PH_HOLD: if (last) begin
          ph_d  = PH_RASLO;
          cnt_d = PCW'(RAS_LOW_CYC - CHR_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
        PH_RASLO: if (last) begin
          ph_d  = PH_PRE;
          cnt_d = PCW'(PRE_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
        PH_PRE: if (last) begin
          ph_d = PH_IDLE;
          done = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int CAS_LINES       = 4,
  parameter bit FAST_SIM        = 1'b0,
  parameter int PWRUP_CYC       = 20000,
  parameter int PWRUP_SIM_CYC   = 50,
  parameter int REF_INT_CYC     = 1562,
  parameter int REF_INT_SIM_CYC = 200,
  parameter int INIT_REFS       = 8,
  parameter int PEND_MAX        = 8,
  parameter int SETUP_CYC       = 1,
  parameter int CHR_CYC         = 1,
  parameter int RAS_LOW_CYC     = 6,
  parameter int RAS_PRE_CYC     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_gnt,
  output logic                 ref_req,
  output logic                 init_done,
  output logic                 str_drv,
  output logic                 ras_n,
  output logic [CAS_LINES-1:0] cas_n,
  output logic                 we_n,
  output logic                 pend_ovf
);
  localparam int PWR_LIM = FAST_SIM ? PWRUP_SIM_CYC : PWRUP_CYC;
  localparam int INT_LIM = FAST_SIM ? REF_INT_SIM_CYC : REF_INT_CYC;

  logic [1:0] rs_q;
  logic       rst_s;
  logic       pwr_done_q, pwr_done_d;
  logic       init_q, init_d;
  logic       pwr_tick, int_tick;
  logic       pend_nz, busy, done;
  logic       seq_ras_n, seq_cas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  dref_tick_timer #(.LIMIT(PWR_LIM)) u_pwr_tmr (
    .clk(clk), .rst_n(rst_s), .en(!pwr_done_q), .tick(pwr_tick)
  );

  dref_tick_timer #(.LIMIT(INT_LIM)) u_int_tmr (
    .clk(clk), .rst_n(rst_s), .en(init_q), .tick(int_tick)
  );

  dref_pend_ctr #(.PEND_MAX(PEND_MAX), .INIT_REFS(INIT_REFS)) u_pend (
    .clk(clk), .rst_n(rst_s), .ld(pwr_tick), .inc(int_tick), .dec(done),
    .nz(pend_nz), .ovf(pend_ovf)
  );

  dref_strobe_seq #(
    .SETUP_CYC(SETUP_CYC), .CHR_CYC(CHR_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC), .PRE_CYC(RAS_PRE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_s), .ce(ref_gnt), .start_ok(pend_nz),
    .busy(busy), .done(done), .ras_n(seq_ras_n), .cas_n(seq_cas_n)
  );

  always_comb begin
    pwr_done_d = pwr_done_q | pwr_tick;
    init_d     = init_q | (pwr_done_q & ~pend_nz & ~busy);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pwr_done_q <= 1'b0;
      init_q     <= 1'b0;
    end else begin
      pwr_done_q <= pwr_done_d;
      init_q     <= init_d;
    end
  end

  assign init_done = init_q;
  assign ref_req   = pend_nz | busy;
  assign str_drv   = ref_gnt & ref_req;
  assign ras_n     = ~str_drv | seq_ras_n;
  assign we_n      = 1'b1;

  for (genvar g = 0; g < CAS_LINES; g++) begin : g_cas
    assign cas_n[g] = ~str_drv | seq_cas_n;
  end
endmodule

// File: rtl/dref_chk.sv
module dref_chk #(
  parameter int CAS_LINES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ref_gnt,
  input logic                 ref_req,
  input logic                 init_done,
  input logic                 str_drv,
  input logic                 ras_n,
  input logic [CAS_LINES-1:0] cas_n,
  input logic                 we_n,
  input logic                 pend_ovf
);
  a_r5_cas_low_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (str_drv && $fell(ras_n)) |-> ($past(cas_n[0]) == 1'b0));

  a_r6_cas_low_at_ras_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (cas_n[0] == 1'b0));

  a_r7_cas_falls_with_ras_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n[0]) |-> (ras_n && $past(ras_n)));

  a_r8_quiet_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_gnt |-> (!str_drv && ras_n && we_n && (cas_n == '1)));

  a_r10_req_held_while_ras_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> ref_req);

  a_r3_init_done_with_req_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> !ref_req);

  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pend_ovf |=> pend_ovf);
endmodule

bind dram_refresh_seq dref_chk #(.CAS_LINES(CAS_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .init_done(init_done), .str_drv(str_drv), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .pend_ovf(pend_ovf)
);

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
  localparam int CL   = 4;
  localparam int PWR  = 50;
  localparam int INTV = 200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_gnt = 1'b0;
  logic          ref_req, init_done, str_drv, ras_n, we_n, pend_ovf;
  logic [CL-1:0] cas_n;

  int total = 0;
  int bad = 0;
  int ras_falls = 0;
  int cyc = 0;
  bit auto_gnt = 1'b0;
  bit finished = 1'b0;

  dram_refresh_seq #(.CAS_LINES(CL), .FAST_SIM(1'b1),
                     .PWRUP_SIM_CYC(PWR), .REF_INT_SIM_CYC(INTV)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .init_done(init_done), .str_drv(str_drv), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .pend_ovf(pend_ovf)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wait_req(input bit v);
    for (int i = 0; i < 1000 && ref_req != v; i++) step(1);
  endtask

  // grant model: follows the request when enabled
  initial begin
    forever begin
      @(negedge clk);
      ref_gnt = auto_gnt & ref_req;
    end
  end

  // strobe monitor
  initial begin
    bit pr = 1'b1, pc = 1'b1;
    int low_run = 0, cas_in_low = 0, high_run = 0;
    forever begin
      step(1);
      if (str_drv) begin
        chk((cas_n == '0) || (cas_n == '1), "R4 cas lines equal", int'(cas_n), 0);
        chk(we_n == 1'b1, "R5 we high while driven", we_n, 1);
      end
      if (!ref_gnt)
        chk(!str_drv && ras_n && we_n && (cas_n == '1), "R8 idle without grant",
            {str_drv, ras_n, we_n}, 3'b011);
      if (pr && !ras_n) begin
        chk(!pc && !cas_n[0], "R5 cas low before and at ras fall", {pc, cas_n[0]}, 0);
        chk(high_run >= 4, "R7 ras precharge width", high_run, 4);
        ras_falls++;
        low_run = 0;
        cas_in_low = 0;
      end
      if (!ras_n) begin
        low_run++;
        if (!cas_n[0]) cas_in_low++;
      end
      if (!pr && ras_n) begin
        chk(low_run == 6, "R6 ras low width", low_run, 6);
        chk(cas_in_low == 1, "R6 cas hold after ras fall", cas_in_low, 1);
      end
      if (pc && !cas_n[0]) chk(ras_n == 1'b1, "R7 cas falls with ras high", ras_n, 1);
      high_run = ras_n ? high_run + 1 : 0;
      pr = ras_n;
      pc = cas_n[0];
    end
  end

  task automatic t_reset;
    step(4);
    chk(ras_n && we_n && (cas_n == '1), "R1 strobes inactive in reset", {ras_n, we_n}, 3);
    chk(!str_drv && !ref_req && !init_done && !pend_ovf, "R1 outputs low in reset",
        {str_drv, ref_req, init_done, pend_ovf}, 0);
  endtask

  task automatic t_powerup;
    auto_gnt = 1'b1;
    rst_n = 1'b1;
    step(1);
    chk(!ref_req && !init_done && !str_drv, "R1 quiet after release",
        {ref_req, init_done, str_drv}, 0);
    step(PWR - 1);
    chk(!ref_req, "R2 no request during pause", ref_req, 0);
    step(3);
    chk(ref_req, "R2 request after pause", ref_req, 1);
    chk(!init_done, "R3 init_done low while initial refreshes pending", init_done, 0);
  endtask

  task automatic t_init;
    for (int i = 0; i < 400 && !init_done; i++) step(1);
    chk(ras_falls == 8, "R3 initial refresh count", ras_falls, 8);
    chk(init_done && !ref_req, "R3 init_done with request low", {init_done, ref_req}, 2);
  endtask

  task automatic t_interval;
    int c0;
    wait_req(1'b1);
    c0 = cyc;
    wait_req(1'b0);
    wait_req(1'b1);
    chk(cyc - c0 == INTV, "R9 refresh period", cyc - c0, INTV);
  endtask

  task automatic t_postpone;
    int f0;
    auto_gnt = 1'b1;
    wait_req(1'b1);
    wait_req(1'b0);
    auto_gnt = 1'b0;
    step(600);
    chk(ref_req && !str_drv, "R10 request held while postponed", {ref_req, str_drv}, 2);
    f0 = ras_falls;
    auto_gnt = 1'b1;
    step(36);
    chk(ras_falls - f0 == 3, "R10 postponed refreshes replayed", ras_falls - f0, 3);
    step(9);
    chk(!ref_req, "R10 request drops after last precharge", ref_req, 0);
  endtask

  task automatic t_overflow;
    int f0;
    wait_req(1'b1);
    wait_req(1'b0);
    auto_gnt = 1'b0;
    step(1600);
    chk(!pend_ovf, "R11 eight pending fit", pend_ovf, 0);
    step(200);
    chk(pend_ovf, "R11 ninth pending sets overflow", pend_ovf, 1);
    f0 = ras_falls;
    auto_gnt = 1'b1;
    step(95);
    chk(ras_falls - f0 == 8, "R11 saturated count replayed", ras_falls - f0, 8);
    step(10);
    chk(!ref_req, "R11 no extra refresh beyond saturation", ref_req, 0);
    chk(pend_ovf, "R11 overflow flag sticky", pend_ovf, 1);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_init();
    t_interval();
    t_postpone();
    t_overflow();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog (R1..R11 run) actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule